// File: doc/BRIEF.md
# Most-Privileged Interrupt-Interface Enable Register

This block holds a 32-bit control word that decides how the most privileged level of a processor reaches its interrupt-controller CPU interface. The word has four live bits: an enable that lets lower levels reach their own sibling enable registers, two bits that turn off the IRQ and FIQ bypass paths, and a bit that selects the system-register interface in place of the memory-mapped one. It also derives the effective values that downstream trap logic uses. The most important of these is an effective enable that is forced high whenever the system-register interface is off.

Accesses arrive as coprocessor-style move-to and move-from requests, with a one-cycle strobe. The block first checks the encoding. It then combines the current privilege level, the hypervisor trap controls and a lockdown input, and reports one outcome for each matching access in the same cycle: done, undefined, trap to the hypervisor running 64-bit, or trap to the hypervisor running 32-bit. Traps carry syndrome code 0x03.

Build-time parameters model simpler implementations. The bypass-disable bits, the interface-select bit and the enable bit can each be tied to read-as-one, write-ignored.

Top module: `mon_ifc_ctrl_reg`

## Requirements
- R1: Bits 31:4 of read data are always zero. The values written to those bits have no effect on the register.
- R2: An access is handled only when the coprocessor field is 15, op1 is 6, the first register field is 12, the second register field is 12 and op2 is 5. Any other encoding gives outcome 0 and leaves the register unchanged.
- R3: A matching access at privilege level 0 or level 2 (priv_lvl 0 or 2) gives the undefined outcome and does not update the register.
- R4: A matching access at level 1 traps only when hyp_enabled and hyp_trap_bit are both 1. The outcome is trap-64 (4'b0100) if hyp_is_64 is 1 and trap-32 (4'b1000) otherwise, and trap_code is 0x03. In every other level-1 case the outcome is undefined (4'b0010). trap_code is 0 whenever the access does not trap.
- R5: At level 3, a read gives done (4'b0001) and returns the register value on rdata. A write gives done and stores bits 3:0 of the data, unless lockdown is 1. A write with lockdown at 1 is undefined and leaves the register unchanged.
- R6: Bit 3 is the enable, bit 2 turns off IRQ bypass, bit 1 turns off FIQ bypass and bit 0 selects the system-register interface. When bit 0 is 0, eff_enable is 1, while the read-back of bit 3 still shows the stored value.
- R7: If IRQ bypass (or FIQ bypass) is not supported, bit 2 (or bit 1) reads as one and ignores writes.
- R8: In the system-register-only build, bit 0 reads as one and ignores writes. When the matching option is also set, bit 3 does the same.
- R9: After reset, the writable bits hold their reset parameter, which is 0 by default, and outcome is 0 while no access is presented.
- R10: outcome is one-hot or zero. It is nonzero exactly when a matching access is strobed, in that same cycle. rdata is zero unless a read completes.
- R11: A completed write that takes bit 0 from 1 to 0 sets sre_drop_seen, which stays set until reset. The register still takes the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = move to register, 0 = move from register |
| acc_cp | input | 4 | Coprocessor number |
| acc_opc1 | input | 3 | Op1 field |
| acc_crn | input | 4 | First register field |
| acc_crm | input | 4 | Second register field |
| acc_opc2 | input | 3 | Op2 field |
| acc_wdata | input | 32 | Write data |
| priv_lvl | input | 2 | Current privilege level, 0 to 3 |
| hyp_enabled | input | 1 | Hypervisor level is enabled |
| hyp_is_64 | input | 1 | Hypervisor runs in 64-bit state |
| hyp_trap_bit | input | 1 | Hypervisor trap control for this register group |
| lockdown | input | 1 | Blocks writes at level 3 |
| outcome | output | 4 | One-hot: bit0 done, bit1 undefined, bit2 trap-64, bit3 trap-32 |
| trap_code | output | 6 | Syndrome code on a trap, else 0 |
| rdata | output | 32 | Read data on a completed read, else 0 |
| eff_enable | output | 1 | Effective enable for lower-level trap logic |
| eff_irq_byp_off | output | 1 | Effective IRQ bypass disable |
| eff_fiq_byp_off | output | 1 | Effective FIQ bypass disable |
| eff_sysreg_en | output | 1 | Effective system-register interface select |
| sre_drop_seen | output | 1 | Sticky flag: interface select was cleared by a write |

## Verification
The assertions check the following on every cycle:
- the outcome stays one-hot or zero, and appears exactly when a matching access is strobed;
- levels 0 and 2 never complete;
- any write that does not complete leaves the stored bits unchanged;
- the effective enable stays high while the interface select is low;
- the upper read bits stay zero;
- the drop flag is sticky.

Only the bench scenarios can show that the stored value matches the written data, that the trap form follows the hypervisor width, and that the read-as-one ties hold in the reduced build. The bench also follows the 1-to-0 transition of the interface select, which sets the drop flag while the register still takes the written data.

// File: rtl/mic_pkg.sv
package mic_pkg;
  localparam int REG_W   = 32;
  localparam int CTRL_W  = 4;
  localparam int CP_W    = 4;
  localparam int OPC1_W  = 3;
  localparam int CR_W    = 4;
  localparam int OPC2_W  = 3;
  localparam int LVL_W   = 2;
  localparam int CODE_W  = 6;

  localparam int BIT_SYS = 0;
  localparam int BIT_FIQ = 1;
  localparam int BIT_IRQ = 2;
  localparam int BIT_EN  = 3;

  localparam logic [CODE_W-1:0] TRAP_SYNDROME = 6'h03;

  typedef enum logic [3:0] {
    OUT_NONE   = 4'b0000,
    OUT_DONE   = 4'b0001,
    OUT_UNDEF  = 4'b0010,
    OUT_TRAP64 = 4'b0100,
    OUT_TRAP32 = 4'b1000
  } outcome_e;

  // Bits tied to read-as-one, write-ignored for a given build.
  function automatic logic [CTRL_W-1:0] rao_mask(bit irq_sup, bit fiq_sup,
                                                 bit sys_only, bit en_rao);
    logic [CTRL_W-1:0] m;
    m          = '0;
    m[BIT_IRQ] = !irq_sup;
    m[BIT_FIQ] = !fiq_sup;
    m[BIT_SYS] = sys_only;
    m[BIT_EN]  = sys_only && en_rao;
    return m;
  endfunction

  // Enable counts as set whenever the system-register interface is off.
  function automatic logic eff_enable_of(logic [CTRL_W-1:0] view);
    return view[BIT_EN] | ~view[BIT_SYS];
  endfunction
endpackage

// File: rtl/mic_acc_decode.sv
module mic_acc_decode #(
  parameter int CP_W   = 4,
  parameter int OPC1_W = 3,
  parameter int CR_W   = 4,
  parameter int OPC2_W = 3,
  parameter logic [CP_W-1:0]   M_CP   = 4'd15,
  parameter logic [OPC1_W-1:0] M_OPC1 = 3'd6,
  parameter logic [CR_W-1:0]   M_CRN  = 4'd12,
  parameter logic [CR_W-1:0]   M_CRM  = 4'd12,
  parameter logic [OPC2_W-1:0] M_OPC2 = 3'd5
) (
  input  logic [CP_W-1:0]   cp,
  input  logic [OPC1_W-1:0] opc1,
  input  logic [CR_W-1:0]   crn,
  input  logic [CR_W-1:0]   crm,
  input  logic [OPC2_W-1:0] opc2,
  output logic              hit
);
  assign hit = (cp == M_CP) && (opc1 == M_OPC1) && (crn == M_CRN) &&
               (crm == M_CRM) && (opc2 == M_OPC2);
endmodule

// File: rtl/mic_outcome_route.sv
module mic_outcome_route
  import mic_pkg::*;
(
  input  logic              req,
  input  logic              write,
  input  logic [LVL_W-1:0]  lvl,
  input  logic              hyp_en,
  input  logic              hyp_64,
  input  logic              hyp_trap,
  input  logic              lock,
  output logic [3:0]        outcome,
  output logic [CODE_W-1:0] code
);
  outcome_e res;

  always_comb begin
    res = OUT_NONE;
    if (req) begin
      unique case (lvl)
        2'd1: begin
          if (hyp_en && hyp_trap) res = hyp_64 ? OUT_TRAP64 : OUT_TRAP32;
          else                    res = OUT_UNDEF;
        end
        2'd3:    res = (write && lock) ? OUT_UNDEF : OUT_DONE;
        default: res = OUT_UNDEF;
      endcase
    end
  end

  assign outcome = res;
  assign code    = (res == OUT_TRAP64 || res == OUT_TRAP32) ? TRAP_SYNDROME : '0;
endmodule

// File: rtl/mic_ctrl_store.sv
module mic_ctrl_store
  import mic_pkg::*;
#(
  parameter logic [CTRL_W-1:0] RAO = '0,
  parameter logic [CTRL_W-1:0] RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] view,
  output logic              drop_seen
);
  localparam logic [CTRL_W-1:0] WMASK = ~RAO;

  logic [CTRL_W-1:0] stored_q;
  logic [CTRL_W-1:0] next_view;
  logic              sys_drop;

  assign view      = stored_q | RAO;
  assign next_view = (wdata & WMASK) | RAO;
  assign sys_drop  = wr_fire && view[BIT_SYS] && !next_view[BIT_SYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stored_q  <= RST & WMASK;
      drop_seen <= 1'b0;
    end else begin
      if (wr_fire)  stored_q  <= wdata & WMASK;
      if (sys_drop) drop_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/mon_ifc_ctrl_reg.sv
module mon_ifc_ctrl_reg
  import mic_pkg::*;
#(
  parameter bit                IRQ_BYP_SUP      = 1'b1,
  parameter bit                FIQ_BYP_SUP      = 1'b1,
  parameter bit                SYSREG_ONLY      = 1'b0,
  parameter bit                EN_RAO_IF_SYSREG = 1'b0,
  parameter logic [CTRL_W-1:0] RST_CTRL         = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [CP_W-1:0]   acc_cp,
  input  logic [OPC1_W-1:0] acc_opc1,
  input  logic [CR_W-1:0]   acc_crn,
  input  logic [CR_W-1:0]   acc_crm,
  input  logic [OPC2_W-1:0] acc_opc2,
  input  logic [REG_W-1:0]  acc_wdata,
  input  logic [LVL_W-1:0]  priv_lvl,
  input  logic              hyp_enabled,
  input  logic              hyp_is_64,
  input  logic              hyp_trap_bit,
  input  logic              lockdown,
  output logic [3:0]        outcome,
  output logic [CODE_W-1:0] trap_code,
  output logic [REG_W-1:0]  rdata,
  output logic              eff_enable,
  output logic              eff_irq_byp_off,
  output logic              eff_fiq_byp_off,
  output logic              eff_sysreg_en,
  output logic              sre_drop_seen
);
  localparam logic [CTRL_W-1:0] RAO =
    rao_mask(IRQ_BYP_SUP, FIQ_BYP_SUP, SYSREG_ONLY, EN_RAO_IF_SYSREG);
  localparam int PAD_W = REG_W - CTRL_W;

  // Named internal events, visible to the bound checker.
  logic              acc_hit;
  logic              acc_req;
  logic              wr_fire;
  logic              rd_fire;
  logic [CTRL_W-1:0] view_q;
  logic              unused_hi;

  assign unused_hi = ^acc_wdata[REG_W-1:CTRL_W];

  mic_acc_decode #(
    .CP_W(CP_W), .OPC1_W(OPC1_W), .CR_W(CR_W), .OPC2_W(OPC2_W)
  ) u_decode (
    .cp(acc_cp), .opc1(acc_opc1), .crn(acc_crn), .crm(acc_crm),
    .opc2(acc_opc2), .hit(acc_hit)
  );

  assign acc_req = acc_valid && acc_hit;

  mic_outcome_route u_route (
    .req(acc_req), .write(acc_write), .lvl(priv_lvl),
    .hyp_en(hyp_enabled), .hyp_64(hyp_is_64), .hyp_trap(hyp_trap_bit),
    .lock(lockdown), .outcome(outcome), .code(trap_code)
  );

  assign wr_fire = (outcome == OUT_DONE) && acc_write;
  assign rd_fire = (outcome == OUT_DONE) && !acc_write;

  mic_ctrl_store #(.RAO(RAO), .RST(RST_CTRL)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire),
    .wdata(acc_wdata[CTRL_W-1:0]), .view(view_q), .drop_seen(sre_drop_seen)
  );

  assign rdata           = rd_fire ? {{PAD_W{1'b0}}, view_q} : '0;
  assign eff_enable      = eff_enable_of(view_q);
  assign eff_irq_byp_off = view_q[BIT_IRQ];
  assign eff_fiq_byp_off = view_q[BIT_FIQ];
  assign eff_sysreg_en   = view_q[BIT_SYS];
endmodule

// File: rtl/mon_ifc_ctrl_chk.sv
module mon_ifc_ctrl_chk
  import mic_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_hit,
  input logic              acc_write,
  input logic [LVL_W-1:0]  priv_lvl,
  input logic [3:0]        outcome,
  input logic [REG_W-1:0]  rdata,
  input logic [CTRL_W-1:0] view_q,
  input logic              eff_enable,
  input logic              eff_sysreg_en,
  input logic              sre_drop_seen
);
  p_outcome_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(outcome));

  p_outcome_when_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((outcome != 4'b0) == (acc_valid && acc_hit)));

  p_low_levels_undef_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_hit && (priv_lvl == 2'd0 || priv_lvl == 2'd2))
      |-> (outcome == OUT_UNDEF));

  p_blocked_write_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && outcome != OUT_DONE) |=> $stable(view_q));

  p_enable_forced_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !eff_sysreg_en |-> eff_enable);

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[REG_W-1:CTRL_W] == '0));

  p_drop_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sre_drop_seen |=> sre_drop_seen);
endmodule

bind mon_ifc_ctrl_reg mon_ifc_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
  .acc_write(acc_write), .priv_lvl(priv_lvl), .outcome(outcome),
  .rdata(rdata), .view_q(view_q), .eff_enable(eff_enable),
  .eff_sysreg_en(eff_sysreg_en), .sre_drop_seen(sre_drop_seen)
);

// File: tb/test_mon_ifc_ctrl_reg.sv
module test_mon_ifc_ctrl_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 0, acc_write = 0;
  logic [3:0]  acc_cp = 0;
  logic [2:0]  acc_opc1 = 0;
  logic [3:0]  acc_crn = 0, acc_crm = 0;
  logic [2:0]  acc_opc2 = 0;
  logic [31:0] acc_wdata = 0;
  logic [1:0]  priv_lvl = 0;
  logic        hyp_enabled = 0, hyp_is_64 = 0, hyp_trap_bit = 0, lockdown = 0;

  logic [3:0]  out_a, out_b;
  logic [5:0]  code_a, code_b;
  logic [31:0] rd_a, rd_b;
  logic        en_a, irq_a, fiq_a, sys_a, drop_a;
  logic        en_b, irq_b, fiq_b, sys_b, drop_b;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  // Bench model state.
  logic [3:0] m_a, m_b;
  logic       d_a, d_b;
  localparam logic [3:0] RAO_B = 4'hF;

  always #2.5 clk = ~clk;

  mon_ifc_ctrl_reg i_mon_ifc_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_cp(acc_cp), .acc_opc1(acc_opc1), .acc_crn(acc_crn), .acc_crm(acc_crm),
    .acc_opc2(acc_opc2), .acc_wdata(acc_wdata), .priv_lvl(priv_lvl),
    .hyp_enabled(hyp_enabled), .hyp_is_64(hyp_is_64), .hyp_trap_bit(hyp_trap_bit),
    .lockdown(lockdown), .outcome(out_a), .trap_code(code_a), .rdata(rd_a),
    .eff_enable(en_a), .eff_irq_byp_off(irq_a), .eff_fiq_byp_off(fiq_a),
    .eff_sysreg_en(sys_a), .sre_drop_seen(drop_a));

  mon_ifc_ctrl_reg #(
    .IRQ_BYP_SUP(1'b0), .FIQ_BYP_SUP(1'b0), .SYSREG_ONLY(1'b1),
    .EN_RAO_IF_SYSREG(1'b1)
  ) i_mon_ifc_ctrl_reg_min (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_cp(acc_cp), .acc_opc1(acc_opc1), .acc_crn(acc_crn), .acc_crm(acc_crm),
    .acc_opc2(acc_opc2), .acc_wdata(acc_wdata), .priv_lvl(priv_lvl),
    .hyp_enabled(hyp_enabled), .hyp_is_64(hyp_is_64), .hyp_trap_bit(hyp_trap_bit),
    .lockdown(lockdown), .outcome(out_b), .trap_code(code_b), .rdata(rd_b),
    .eff_enable(en_b), .eff_irq_byp_off(irq_b), .eff_fiq_byp_off(fiq_b),
    .eff_sysreg_en(sys_b), .sre_drop_seen(drop_b));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic enc_ok(logic [3:0] cp, logic [2:0] o1, logic [3:0] rn,
                                  logic [3:0] rm, logic [2:0] o2);
    return cp == 4'd15 && o1 == 3'd6 && rn == 4'd12 && rm == 4'd12 && o2 == 3'd5;
  endfunction

  // Expected outcome, restated from R2..R5.
  function automatic logic [3:0] exp_out(logic v, logic hit, logic wr, logic [1:0] lv,
                                         logic he, logic h64, logic tb, logic lk);
    if (!(v && hit)) return 4'b0000;
    if (lv == 2'd3) return (wr && lk) ? 4'b0010 : 4'b0001;
    if (lv == 2'd1 && he && tb) return h64 ? 4'b0100 : 4'b1000;
    return 4'b0010;
  endfunction

  task automatic check_eff();
    chk("R6 eff_enable", {31'b0, en_a}, {31'b0, m_a[3] | ~m_a[0]});
    chk("R6 eff_irq", {31'b0, irq_a}, {31'b0, m_a[2]});
    chk("R6 eff_fiq", {31'b0, fiq_a}, {31'b0, m_a[1]});
    chk("R6 eff_sys", {31'b0, sys_a}, {31'b0, m_a[0]});
    chk("R11 drop flag", {31'b0, drop_a}, {31'b0, d_a});
    chk("R8 reduced eff", {27'b0, en_b, irq_b, fiq_b, sys_b, drop_b}, {27'b0, 4'hF, d_b});
  endtask

  task automatic do_acc(logic v, logic wr, logic [3:0] cp, logic [2:0] o1,
                        logic [3:0] rn, logic [3:0] rm, logic [2:0] o2,
                        logic [31:0] wd, logic [1:0] lv, logic he, logic h64,
                        logic tb, logic lk, string tag);
    logic [3:0] eo;
    @(negedge clk);
    acc_valid = v; acc_write = wr; acc_cp = cp; acc_opc1 = o1; acc_crn = rn;
    acc_crm = rm; acc_opc2 = o2; acc_wdata = wd; priv_lvl = lv;
    hyp_enabled = he; hyp_is_64 = h64; hyp_trap_bit = tb; lockdown = lk;
    #1;
    eo = exp_out(v, enc_ok(cp, o1, rn, rm, o2), wr, lv, he, h64, tb, lk);
    chk({tag, " outcome"}, {28'b0, out_a}, {28'b0, eo});
    chk({tag, " outcome reduced"}, {28'b0, out_b}, {28'b0, eo});
    chk({tag, " R4 trap_code"}, {26'b0, code_a},
        (eo == 4'b0100 || eo == 4'b1000) ? 32'h3 : 32'h0);
    chk({tag, " R10 rdata"}, rd_a, (eo == 4'b0001 && !wr) ? {28'b0, m_a} : 32'h0);
    chk({tag, " R7 R8 rdata reduced"}, rd_b,
        (eo == 4'b0001 && !wr) ? 32'hF : 32'h0);
    if (eo == 4'b0001 && wr) begin
      if (m_a[0] && !wd[0]) d_a = 1'b1;
      m_a = wd[3:0];
      m_b = (wd[3:0] & ~RAO_B) | RAO_B;
    end
    @(posedge clk);
    #1;
    acc_valid = 1'b0;
    check_eff();
  endtask

  // Level-3 helpers with the matching encoding.
  task automatic wr3(logic [31:0] wd, logic lk, string tag);
    do_acc(1, 1, 4'd15, 3'd6, 4'd12, 4'd12, 3'd5, wd, 2'd3, 0, 0, 0, lk, tag);
  endtask
  task automatic rd3(string tag);
    do_acc(1, 0, 4'd15, 3'd6, 4'd12, 4'd12, 3'd5, 32'h0, 2'd3, 0, 0, 0, 0, tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    m_a = 4'h0; m_b = 4'hF; d_a = 0; d_b = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9: reset state.
    chk("R9 outcome idle", {28'b0, out_a}, 32'h0);
    check_eff();
    rd3("R9 reset read");
    // R1, R5: all ones, upper bits dropped.
    wr3(32'hFFFF_FFFF, 0, "R5 write ones");
    rd3("R1 upper zero");
    // R6: enable stored 1 but interface select 0.
    wr3(32'h0000_0008, 0, "R11 drop to zero");
    rd3("R6 readback");
    wr3(32'hFFFF_FFF0, 0, "R6 enable forced");
    rd3("R1 R6 readback zero");
    // R5: lockdown blocks a write.
    wr3(32'h0000_0005, 0, "R5 set");
    wr3(32'h0000_000A, 1, "R5 lockdown write");
    rd3("R5 after lockdown");
    // R3: levels 0 and 2.
    do_acc(1, 1, 4'd15, 3'd6, 4'd12, 4'd12, 3'd5, 32'h0, 2'd0, 1, 1, 1, 0, "R3 lvl0");
    do_acc(1, 1, 4'd15, 3'd6, 4'd12, 4'd12, 3'd5, 32'h0, 2'd2, 1, 1, 1, 0, "R3 lvl2");
    // R4: trap forms and no-trap.
    do_acc(1, 0, 4'd15, 3'd6, 4'd12, 4'd12, 3'd5, 32'h0, 2'd1, 1, 1, 1, 0, "R4 trap64");
    do_acc(1, 1, 4'd15, 3'd6, 4'd12, 4'd12, 3'd5, 32'h0, 2'd1, 1, 0, 1, 0, "R4 trap32");
    do_acc(1, 1, 4'd15, 3'd6, 4'd12, 4'd12, 3'd5, 32'h0, 2'd1, 0, 1, 1, 0, "R4 no hyp");
    // R2: near-miss encodings at level 3.
    do_acc(1, 1, 4'd14, 3'd6, 4'd12, 4'd12, 3'd5, 32'h0, 2'd3, 0, 0, 0, 0, "R2 cp");
    do_acc(1, 1, 4'd15, 3'd6, 4'd12, 4'd12, 3'd4, 32'h0, 2'd3, 0, 0, 0, 0, "R2 opc2");
    rd3("R2 unchanged");
    // Random mix.
    for (int i = 0; i < 3000; i++) begin
      logic hitp;
      logic [3:0] cp, rn, rm;
      logic [2:0] o1, o2;
      hitp = ($urandom % 4) != 0;
      cp = hitp ? 4'd15 : 4'($urandom);
      o1 = hitp ? 3'd6  : 3'($urandom);
      rn = hitp ? 4'd12 : 4'($urandom);
      rm = hitp ? 4'd12 : 4'($urandom);
      o2 = hitp ? 3'd5  : 3'($urandom);
      do_acc(($urandom % 8) != 0, 1'($urandom), cp, o1, rn, rm, o2, $urandom,
             2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             ($urandom % 4) == 0, "R10 random");
    end
    summary();
  end
endmodule